// File: doc/BRIEF.md
# Constant-coefficient multiplier with signed-digit recoding

This block multiplies one operand by a coefficient fixed when the design is elaborated. It is purely combinational. At elaboration the coefficient is rewritten in canonical non-adjacent form, where each digit is -1, 0 or +1 and no two nonzero digits are neighbours. Each nonzero digit becomes one shifted copy of the operand, so a 16-bit coefficient needs at most nine terms and usually far fewer. A negative digit enters the sum as the bitwise complement of its shifted copy. The +1 that completes its two's-complement negation goes into the free least-significant bit of a carry vector, or into the carry-in of the final adder.

All terms are reduced together by levels of 3:2 carry-save compressors until two vectors remain. One carry-propagate adder then forms the product. The operand is read as unsigned by default. A parameter switches it to two's complement, and the product is then a signed value of the same width.

Top module: `csd_const_mult`

## Requirements
- R1: With `SIGNED_IN` = 0, `p` equals the unsigned product of `a` and `K`, both zero-extended to IN_W+K_W bits, for every value of `a`.
- R2: With `SIGNED_IN` = 1, `a` is read as two's complement and `p` is the two's-complement product of `a` and the unsigned coefficient `K`, IN_W+K_W bits wide. This includes the most negative input, 0x8000.
- R3: An input of zero gives a product of zero for every coefficient and in both signedness modes.
- R4: An input of one gives `K` zero-extended to the product width.
- R5: An all-ones input (0xFFFF) gives (2^16-1)·K when unsigned and −K, in two's complement, when signed.
- R6: With `K` = 0 the product is zero for every input.
- R7: With `K` = 1 the product is the input, extended to the product width by zeros when unsigned and by its sign bit when signed.
- R8: With `K` = 0xFFFF, which recodes to one positive and one negative term, the product is correct for every input. Here the negation's +1 reaches the final adder's carry-in.
- R9: A coefficient whose recoding has several negative digits (0xB6DB) gives the correct product. Each negation's +1 must be absorbed by a distinct carry slot.
- R10: With the default coefficient 0x3E3E, which recodes to +2^14 −2^9 +2^6 −2^1, the product is correct for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | IN_W | Multiplicand, unsigned or two's complement according to `SIGNED_IN` |
| p | output | IN_W+K_W | Product of `a` and the elaboration-time coefficient `K` |

## Verification
The hardest condition to reach is a correction +1 that is lost, or placed twice, in the carry slots. The product is then off by exactly one or two times a small power of two, and only for inputs whose complemented terms carry far enough to show it. The stimulus therefore runs the same inputs through several coefficients that differ in how many negative digits they have and where they sit. It drives thousands of random operands plus the extremes 0, 1, 0x7FFF, 0x8000 and 0xFFFF, which set the complemented terms to all-ones or all-zeros patterns. A misplaced correction then appears in some output bit.

// File: rtl/csd_pkg.sv
package csd_pkg;

  // Canonical non-adjacent recoding of k: mask of positive (want_neg=0)
  // or negative (want_neg=1) digit positions.
  function automatic logic [63:0] naf_mask(input logic [63:0] k, input bit want_neg);
    logic [64:0] x;
    logic [63:0] m;
    x = {1'b0, k};
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (x[0]) begin
        if (x[1]) begin
          if (want_neg) m[i] = 1'b1;
          x = x + 65'd1;
        end else begin
          if (!want_neg) m[i] = 1'b1;
          x = x - 65'd1;
        end
      end
      x = x >> 1;
    end
    return m;
  endfunction

  function automatic int ones(input logic [63:0] m);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(m[i]);
    return n;
  endfunction

  // Bit position of the n-th set bit (counting from zero, LSB first).
  function automatic int nth_set(input logic [63:0] m, input int n);
    int seen;
    int pos;
    seen = 0;
    pos  = 0;
    for (int i = 0; i < 64; i++) begin
      if (m[i]) begin
        if (seen == n) pos = i;
        seen++;
      end
    end
    return pos;
  endfunction

  // Operand count entering reduction level l.
  function automatic int lvl_count(input int n0, input int l);
    int n;
    n = n0;
    for (int j = 0; j < l; j++) n = 2 * (n / 3) + n % 3;
    return n;
  endfunction

  // First slot of level l in the flat operand bus.
  function automatic int lvl_base(input int n0, input int l);
    int b;
    b = 0;
    for (int j = 0; j < l; j++) b += lvl_count(n0, j);
    return b;
  endfunction

  // Number of compressors placed in the levels before l.
  function automatic int csa_base(input int n0, input int l);
    int b;
    b = 0;
    for (int j = 0; j < l; j++) b += lvl_count(n0, j) / 3;
    return b;
  endfunction

  function automatic int lvl_depth(input int n0);
    int n;
    int d;
    n = n0;
    d = 0;
    while (n > 2) begin
      n = 2 * (n / 3) + n % 3;
      d++;
    end
    return d;
  endfunction

endpackage

// File: rtl/csd_term_gen.sv
module csd_term_gen
  import csd_pkg::*;
#(
  parameter int          IN_W      = 16,
  parameter int          K_W       = 16,
  parameter int          P_W       = 32,
  parameter int          NOP       = 2,
  parameter int          NT        = 0,
  parameter logic [63:0] NZ_M      = '0,
  parameter logic [63:0] NEG_M     = '0,
  parameter bit          SIGNED_IN = 1'b0
) (
  input  logic [IN_W-1:0]          a,
  output logic [NOP-1:0][P_W-1:0]  terms
);

  logic [P_W-1:0] ext;

  generate
    if (SIGNED_IN) begin : g_sext
      assign ext = {{K_W{a[IN_W-1]}}, a};
    end else begin : g_zext
      assign ext = {{K_W{1'b0}}, a};
    end

    for (genvar t = 0; t < NOP; t++) begin : g_term
      if (t < NT) begin : g_live
        localparam int SH  = nth_set(NZ_M, t);
        localparam bit NEG = NEG_M[SH];
        if (NEG) begin : g_neg
          // one's complement here; the +1 is supplied by a carry slot
          assign terms[t] = ~(ext << SH);
        end else begin : g_pos
          assign terms[t] = ext << SH;
        end
      end else begin : g_pad
        assign terms[t] = '0;
      end
    end
  endgenerate

endmodule

// File: rtl/csd_csa.sv
module csd_csa #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);

  logic [W-2:0] maj;

  assign s   = x ^ y ^ z;
  assign maj = (x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) | (y[W-2:0] & z[W-2:0]);
  // carry vector shifts up one place; its free LSB takes a correction bit
  assign c   = {maj, cin};

endmodule

// File: rtl/csd_final_add.sv
module csd_final_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum
);

  assign sum = x + y + {{(W-1){1'b0}}, cin};

endmodule

// File: rtl/csd_const_mult.sv
module csd_const_mult
  import csd_pkg::*;
#(
  parameter int             IN_W      = 16,
  parameter int             K_W       = 16,
  parameter logic [K_W-1:0] K         = 16'h3E3E,
  parameter bit             SIGNED_IN = 1'b0
) (
  input  logic [IN_W-1:0]     a,
  output logic [IN_W+K_W-1:0] p
);

  localparam int          P_W    = IN_W + K_W;
  localparam logic [63:0] POS_M  = naf_mask(64'(K), 1'b0);
  localparam logic [63:0] NEG_M  = naf_mask(64'(K), 1'b1);
  localparam logic [63:0] NZ_M   = POS_M | NEG_M;
  localparam int          NT     = ones(NZ_M);
  localparam int          N_NEG  = ones(NEG_M);
  localparam int          NOP    = (NT < 2) ? 2 : NT;
  localparam int          DEPTH  = lvl_depth(NOP);
  localparam int          NCSA   = NOP - 2;
  localparam int          TOT    = lvl_base(NOP, DEPTH + 1);
  localparam int          FIN    = lvl_base(NOP, DEPTH);
  localparam bit          FIN_CI = (N_NEG > NCSA);

  logic [TOT-1:0][P_W-1:0] bus;

  csd_term_gen #(
    .IN_W(IN_W), .K_W(K_W), .P_W(P_W), .NOP(NOP), .NT(NT),
    .NZ_M(NZ_M), .NEG_M(NEG_M), .SIGNED_IN(SIGNED_IN)
  ) u_terms (
    .a     (a),
    .terms (bus[NOP-1:0])
  );

  generate
    for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
      localparam int N  = lvl_count(NOP, l);
      localparam int NG = N / 3;
      localparam int IB = lvl_base(NOP, l);
      localparam int OB = lvl_base(NOP, l + 1);
      localparam int CB = csa_base(NOP, l);

      for (genvar g = 0; g < NG; g++) begin : g_csa
        localparam bit CI = (CB + g < N_NEG);
        csd_csa #(.W(P_W)) u_csa (
          .x   (bus[IB + 3*g]),
          .y   (bus[IB + 3*g + 1]),
          .z   (bus[IB + 3*g + 2]),
          .cin (CI),
          .s   (bus[OB + 2*g]),
          .c   (bus[OB + 2*g + 1])
        );
      end

      for (genvar r = 0; r < N % 3; r++) begin : g_pass
        assign bus[OB + 2*NG + r] = bus[IB + 3*NG + r];
      end
    end
  endgenerate

  csd_final_add #(.W(P_W)) u_add (
    .x   (bus[FIN]),
    .y   (bus[FIN + 1]),
    .cin (FIN_CI),
    .sum (p)
  );

endmodule

// File: rtl/csd_const_mult_chk.sv
module csd_const_mult_chk #(
  parameter int             IN_W      = 16,
  parameter int             K_W       = 16,
  parameter logic [K_W-1:0] K         = 16'h3E3E,
  parameter bit             SIGNED_IN = 1'b0
) (
  input logic [IN_W-1:0]     a,
  input logic [IN_W+K_W-1:0] p
);

  localparam int P_W = IN_W + K_W;

  logic [P_W-1:0] a_ext;
  logic [P_W-1:0] ref_p;

  always_comb begin
    a_ext = SIGNED_IN ? {{K_W{a[IN_W-1]}}, a} : {{K_W{1'b0}}, a};
    ref_p = a_ext * {{IN_W{1'b0}}, K};

    // R1 / R2: product matches the arithmetic product in the chosen mode
    p_product_r1: assert (p == ref_p)
      else $error("product %h expected %h", p, ref_p);

    p_zero_r3: assert (a != '0 || p == '0)
      else $error("zero input gave %h", p);

    p_unity_r4: assert (a != {{(IN_W-1){1'b0}}, 1'b1} || p == {{IN_W{1'b0}}, K})
      else $error("unit input gave %h", p);

    // R2: in signed mode a nonzero product carries the input's sign
    p_sign_r2: assert (!SIGNED_IN || a == '0 || K == '0 || p[P_W-1] == a[IN_W-1])
      else $error("sign of %h wrong for input %h", p, a);
  end

endmodule

bind csd_const_mult csd_const_mult_chk #(
  .IN_W(IN_W), .K_W(K_W), .K(K), .SIGNED_IN(SIGNED_IN)
) u_chk (
  .a (a),
  .p (p)
);

// File: tb/csd_const_mult_test.sv
module csd_const_mult_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic [15:0] a;
  logic [31:0] p_u, p_s, p_k0, p_k1, p_kf, p_kfs, p_mx;

  int checks;
  int errors;
  int cycles;
  bit done;

  csd_const_mult #(.K(16'h3E3E), .SIGNED_IN(1'b0)) uut    (.a(a), .p(p_u));
  csd_const_mult #(.K(16'h3E3E), .SIGNED_IN(1'b1)) u_sgn  (.a(a), .p(p_s));
  csd_const_mult #(.K(16'h0000), .SIGNED_IN(1'b0)) u_k0   (.a(a), .p(p_k0));
  csd_const_mult #(.K(16'h0001), .SIGNED_IN(1'b1)) u_k1   (.a(a), .p(p_k1));
  csd_const_mult #(.K(16'hFFFF), .SIGNED_IN(1'b0)) u_kf   (.a(a), .p(p_kf));
  csd_const_mult #(.K(16'hFFFF), .SIGNED_IN(1'b1)) u_kfs  (.a(a), .p(p_kfs));
  csd_const_mult #(.K(16'hB6DB), .SIGNED_IN(1'b0)) u_mix  (.a(a), .p(p_mx));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] exp_u(input logic [15:0] x, input logic [15:0] k);
    return {16'b0, x} * {16'b0, k};
  endfunction

  function automatic logic [31:0] exp_s(input logic [15:0] x, input logic [15:0] k);
    return {{16{x[15]}}, x} * {16'b0, k};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s a=%h actual=%h expected=%h", req, a, act, expv);
    end
  endtask

  task automatic apply(input logic [15:0] v, input string tg);
    @(posedge clk);
    a = v;
    @(negedge clk);
    chk((tg == "") ? "R10" : tg, p_u,  exp_u(v, 16'h3E3E));
    chk((tg == "") ? "R2"  : tg, p_s,  exp_s(v, 16'h3E3E));
    chk("R6", p_k0,  32'd0);
    chk("R7", p_k1,  exp_s(v, 16'h0001));
    chk("R8", p_kf,  exp_u(v, 16'hFFFF));
    chk("R8", p_kfs, exp_s(v, 16'hFFFF));
    chk("R9", p_mx,  exp_u(v, 16'hB6DB));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    cycles = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    a      = '0;
    void'($urandom(32'h5EED_0042));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R3: zero input, every coefficient and mode
    apply(16'h0000, "R3");
    // R4: unit input returns the coefficient
    apply(16'h0001, "R4");
    // R5: all-ones input
    apply(16'hFFFF, "R5");
    // R2: signed extremes
    apply(16'h8000, "R2");
    apply(16'h7FFF, "R2");
    apply(16'h0002, "");
    apply(16'hAAAA, "");
    apply(16'h5555, "");

    // R1 / R10: unsigned product against reference at explicit points
    @(negedge clk);
    chk("R1", p_u, {16'b0, a} * 32'h0000_3E3E);

    for (int i = 0; i < N_RAND; i++) begin
      apply(16'($urandom), "");
    end

    @(negedge clk);
    chk("R1", p_u, exp_u(a, 16'h3E3E));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule